// File: doc/BRIEF.md
# Indirect Configuration and I/O Data Port

This block gives a host register port indirect reach into the configuration space and the I/O space behind a host bridge. Software first writes a 32-bit pointer into an address register. It then touches one of two data windows: the configuration window or the I/O window. Each legal data window access turns into exactly one downstream request. That request carries an address, a size, a direction, write data and a flag that tells configuration space from I/O space. The block does not run the downstream cycle itself.

The address register keeps every bit that was written, so a readback returns the raw value. The downstream side only ever sees that value with its two low bits forced to zero. The byte lane of the data window access then fills in those two bits. Each window enforces which sizes are allowed at which byte lane. An access that breaks those rules gets an error response and produces no request. Multi-byte writes through the I/O window are sent big-endian. Configuration writes pass through in little-endian order.

Host encodings: `hRegSel` 0 selects the address register, 1 the configuration window, 2 the I/O window, and 3 is reserved. `hSize` 0 means one byte, 1 two bytes, 2 four bytes, and 3 is reserved. `hLane` is the byte offset, 0 to 3, inside the selected register.

Top module: `cfg_io_port`

## Requirements
- R1: After reset, a word read of the address register returns 0.
- R2: A word read of the address register returns the last value written to it, bits 1:0 included.
- R3: The address register accepts only hSize=2 at hLane=0. Any other size or lane gives hErr, and the stored value does not change.
- R4: A legal configuration window access issues a request with dIsIo=0 and dAddr = (stored value with bits 1:0 cleared) OR hLane. It is issued whatever the value of bit 31 of the stored value.
- R5: A legal I/O window access issues a request with dIsIo=1 and dAddr = (stored value with bits 1:0 cleared) + hLane.
- R6: The same legality rules apply to both data windows. At lane 0, sizes 0, 1 and 2 are legal. At lane 2, only sizes 0 and 1 are legal. At lanes 1 and 3, only size 0 is legal. Size 3 is never legal.
- R7: An illegal access or an hRegSel of 3 raises hErr and gives no dValid.
- R8: Write data on dWdata holds the byte for address dAddr+k in bits 8k+7:8k, and bytes beyond the access size are zero. For the I/O window, the most significant byte of the right-aligned host value goes to the lowest address (big-endian). For the configuration window, the least significant byte goes to the lowest address.
- R9: Every request gets exactly one response, hAck or hErr, one cycle after hValid. A legal data window access raises dValid in that same cycle, with dWrite and dSize copied from the request. A read of a data window shows dWdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hValid | input | 1 | Host request strobe, one cycle |
| hWrite | input | 1 | 1 = write, 0 = read |
| hRegSel | input | 2 | 0 address reg, 1 config window, 2 I/O window, 3 reserved |
| hLane | input | 2 | Byte offset within the selected register |
| hSize | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 reserved |
| hWdata | input | 32 | Right-aligned host write value |
| hAck | output | 1 | Request accepted |
| hErr | output | 1 | Request rejected |
| hRdata | output | 32 | Address register readback, valid with hAck |
| dValid | output | 1 | Downstream request strobe |
| dIsIo | output | 1 | 1 = I/O space, 0 = configuration space |
| dWrite | output | 1 | Downstream direction |
| dSize | output | 2 | Downstream size, same encoding as hSize |
| dAddr | output | 32 | Downstream byte address |
| dWdata | output | 32 | Downstream write data, byte k for address dAddr+k |

## Verification
The hardest case to reach from the ports is a rejected access to the address register. A wrong result would have to show up in a later readback, not in the cycle where the error happens. The bench stores a known value with odd low bits and then sends partial-size and off-lane writes carrying a different pattern. After those writes it reads the register back and expects the original value. The data window table runs against that same odd stored value, with bit 31 clear. This shows that both windows drop the low bits from the base, replace them with the lane, and still issue configuration cycles without an enable bit.

// File: rtl/cfg_io_port_pkg.sv
package cfg_io_port_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_IO   = 2'd2,
    SEL_RSVD = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef struct packed {
    logic ack;
    logic err;
    logic loadAddr;
    logic readAddr;
    logic issue;
    logic isIo;
  } strobe_t;

endpackage

// File: rtl/cfg_io_port_ctrl.sv
module cfg_io_port_ctrl
  import cfg_io_port_pkg::*;
(
  input  logic        hValid,
  input  logic        hWrite,
  input  logic [1:0]  hRegSel,
  input  logic [1:0]  hLane,
  input  logic [1:0]  hSize,
  output strobe_t     strobes
);

  logic dataLegal;
  logic addrLegal;

  // Size-per-lane legality shared by both data windows
  always_comb begin
    unique case (hLane)
      2'd0:    dataLegal = (hSize != SZ_RSVD);
      2'd2:    dataLegal = (hSize == SZ_BYTE) || (hSize == SZ_HALF);
      default: dataLegal = (hSize == SZ_BYTE);
    endcase
  end

  assign addrLegal = (hSize == SZ_WORD) && (hLane == 2'd0);

  always_comb begin
    strobes = '0;
    if (hValid) begin
      unique case (regSel_e'(hRegSel))
        SEL_ADDR: begin
          if (addrLegal) begin
            strobes.ack      = 1'b1;
            strobes.loadAddr = hWrite;
            strobes.readAddr = !hWrite;
          end else begin
            strobes.err = 1'b1;
          end
        end
        SEL_CFG, SEL_IO: begin
          if (dataLegal) begin
            strobes.ack   = 1'b1;
            strobes.issue = 1'b1;
            strobes.isIo  = (hRegSel == SEL_IO);
          end else begin
            strobes.err = 1'b1;
          end
        end
        default: strobes.err = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cfg_io_port_dp.sv
module cfg_io_port_dp
  import cfg_io_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              hWrite,
  input  logic [1:0]        hLane,
  input  logic [1:0]        hSize,
  input  logic [DATA_W-1:0] hWdata,
  output logic              hAck,
  output logic              hErr,
  output logic [DATA_W-1:0] hRdata,
  output logic              dValid,
  output logic              dIsIo,
  output logic              dWrite,
  output logic [1:0]        dSize,
  output logic [ADDR_W-1:0] dAddr,
  output logic [DATA_W-1:0] dWdata
);

  logic [ADDR_W-1:0] rawAddr;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] leData;
  logic [DATA_W-1:0] beData;
  logic [LANES-1:0]  laneUsed;

  assign baseAddr = {rawAddr[ADDR_W-1:2], 2'b00};
  // Low bits of the base are zero, so OR and add give the same address
  assign reqAddr  = baseAddr | {{(ADDR_W-2){1'b0}}, hLane};

  // Which byte lanes the access size covers
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_used
      assign laneUsed[i] = (i < (1 << hSize));
    end
  endgenerate

  // Little-endian: byte i of the value goes to address +i
  // Big-endian: byte (n-1-i) of the value goes to address +i
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] swapByte;
      always_comb begin
        swapByte = 8'h00;
        for (int n = 1; n <= LANES; n = n * 2) begin
          if ((1 << hSize) == n && i < n)
            swapByte = hWdata[8*(n-1-i) +: 8];
        end
      end
      assign leData[8*i +: 8] = laneUsed[i] ? hWdata[8*i +: 8] : 8'h00;
      assign beData[8*i +: 8] = laneUsed[i] ? swapByte : 8'h00;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawAddr <= '0;
      hAck    <= 1'b0;
      hErr    <= 1'b0;
      hRdata  <= '0;
      dValid  <= 1'b0;
      dIsIo   <= 1'b0;
      dWrite  <= 1'b0;
      dSize   <= 2'd0;
      dAddr   <= '0;
      dWdata  <= '0;
    end else begin
      hAck   <= strobes.ack;
      hErr   <= strobes.err;
      dValid <= strobes.issue;
      hRdata <= strobes.readAddr ? rawAddr : '0;
      if (strobes.loadAddr) rawAddr <= hWdata;
      if (strobes.issue) begin
        dIsIo  <= strobes.isIo;
        dWrite <= hWrite;
        dSize  <= hSize;
        dAddr  <= reqAddr;
        dWdata <= !hWrite ? '0 : (strobes.isIo ? beData : leData);
      end
    end
  end

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
  import cfg_io_port_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hValid,
  input  logic        hWrite,
  input  logic [1:0]  hRegSel,
  input  logic [1:0]  hLane,
  input  logic [1:0]  hSize,
  input  logic [31:0] hWdata,
  output logic        hAck,
  output logic        hErr,
  output logic [31:0] hRdata,
  output logic        dValid,
  output logic        dIsIo,
  output logic        dWrite,
  output logic [1:0]  dSize,
  output logic [31:0] dAddr,
  output logic [31:0] dWdata
);

  strobe_t strobes;

  cfg_io_port_ctrl u_ctrl (
    .hValid (hValid),
    .hWrite (hWrite),
    .hRegSel(hRegSel),
    .hLane  (hLane),
    .hSize  (hSize),
    .strobes(strobes)
  );

  cfg_io_port_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .hWrite (hWrite),
    .hLane  (hLane),
    .hSize  (hSize),
    .hWdata (hWdata),
    .hAck   (hAck),
    .hErr   (hErr),
    .hRdata (hRdata),
    .dValid (dValid),
    .dIsIo  (dIsIo),
    .dWrite (dWrite),
    .dSize  (dSize),
    .dAddr  (dAddr),
    .dWdata (dWdata)
  );

endmodule

// File: rtl/cfg_io_port_chk.sv
module cfg_io_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hValid,
  input logic [1:0]  hRegSel,
  input logic [1:0]  hLane,
  input logic [1:0]  hSize,
  input logic        hAck,
  input logic        hErr,
  input logic        dValid,
  input logic        dIsIo,
  input logic [31:0] dAddr
);

  a_r9_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    hValid |=> (hAck || hErr));

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !hValid |=> !(hAck || hErr || dValid));

  a_r9_single_resp: assert property (@(posedge clk) disable iff (!rstN)
    !(hAck && hErr));

  a_r7_err_no_req: assert property (@(posedge clk) disable iff (!rstN)
    hErr |-> !dValid);

  a_r7_rsvd_sel: assert property (@(posedge clk) disable iff (!rstN)
    (hValid && hRegSel == 2'd3) |=> hErr);

  a_r6_odd_lane: assert property (@(posedge clk) disable iff (!rstN)
    (hValid && hRegSel != 2'd0 && hLane[0] && hSize != 2'd0) |=> hErr);

  a_r4_lane_bits: assert property (@(posedge clk) disable iff (!rstN)
    (hValid && hRegSel != 2'd0) |=> (!dValid || dAddr[1:0] == $past(hLane)));

  a_r3_addr_word: assert property (@(posedge clk) disable iff (!rstN)
    (hValid && hRegSel == 2'd0 && hSize != 2'd2) |=> hErr);

  a_r5_space_flag: assert property (@(posedge clk) disable iff (!rstN)
    (hValid && hRegSel == 2'd2) |=> (!dValid || dIsIo));

endmodule

bind cfg_io_port cfg_io_port_chk u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .hValid (hValid),
  .hRegSel(hRegSel),
  .hLane  (hLane),
  .hSize  (hSize),
  .hAck   (hAck),
  .hErr   (hErr),
  .dValid (dValid),
  .dIsIo  (dIsIo),
  .dAddr  (dAddr)
);

// File: tb/sim_cfg_io_port.sv
module sim_cfg_io_port;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hValid = 1'b0;
  logic        hWrite = 1'b0;
  logic [1:0]  hRegSel = 2'd0;
  logic [1:0]  hLane = 2'd0;
  logic [1:0]  hSize = 2'd0;
  logic [31:0] hWdata = '0;
  logic        hAck, hErr, dValid, dIsIo, dWrite;
  logic [31:0] hRdata, dAddr, dWdata;
  logic [1:0]  dSize;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  cfg_io_port u0 (
    .clk(clk), .rstN(rstN), .hValid(hValid), .hWrite(hWrite),
    .hRegSel(hRegSel), .hLane(hLane), .hSize(hSize), .hWdata(hWdata),
    .hAck(hAck), .hErr(hErr), .hRdata(hRdata), .dValid(dValid),
    .dIsIo(dIsIo), .dWrite(dWrite), .dSize(dSize), .dAddr(dAddr),
    .dWdata(dWdata)
  );

  typedef struct packed {
    logic [1:0]  sel;
    logic        wr;
    logic [1:0]  lane;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic        expErr;
    logic [31:0] expAddr;
    logic [31:0] expData;
  } vec_t;

  // Stored address is 32'h0000_0A07 (bit 31 clear), so the base is 32'h0A04
  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 1'b1, 2'd0, 2'd2, 32'h11223344, 1'b0, 32'h0A04, 32'h11223344},
    '{2'd1, 1'b1, 2'd2, 2'd1, 32'h0000AABB, 1'b0, 32'h0A06, 32'h0000AABB},
    '{2'd1, 1'b1, 2'd3, 2'd0, 32'hFFFFFF5A, 1'b0, 32'h0A07, 32'h0000005A},
    '{2'd2, 1'b1, 2'd0, 2'd2, 32'h11223344, 1'b0, 32'h0A04, 32'h44332211},
    '{2'd2, 1'b1, 2'd2, 2'd1, 32'h0000AABB, 1'b0, 32'h0A06, 32'h0000BBAA},
    '{2'd2, 1'b1, 2'd1, 2'd0, 32'h777777C3, 1'b0, 32'h0A05, 32'h000000C3},
    '{2'd2, 1'b1, 2'd0, 2'd1, 32'h99991234, 1'b0, 32'h0A04, 32'h00003412},
    '{2'd2, 1'b0, 2'd0, 2'd2, 32'hDEADBEEF, 1'b0, 32'h0A04, 32'h00000000},
    '{2'd2, 1'b1, 2'd1, 2'd1, 32'h00000000, 1'b1, 32'h0, 32'h0},
    '{2'd2, 1'b1, 2'd2, 2'd2, 32'h00000000, 1'b1, 32'h0, 32'h0},
    '{2'd2, 1'b1, 2'd3, 2'd1, 32'h00000000, 1'b1, 32'h0, 32'h0},
    '{2'd1, 1'b1, 2'd1, 2'd2, 32'h00000000, 1'b1, 32'h0, 32'h0},
    '{2'd2, 1'b1, 2'd0, 2'd3, 32'h00000000, 1'b1, 32'h0, 32'h0},
    '{2'd3, 1'b1, 2'd0, 2'd2, 32'h00000000, 1'b1, 32'h0, 32'h0}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample the registered response one cycle later
  task automatic request(input logic [1:0] sel, input logic wr, input logic [1:0] lane,
                         input logic [1:0] size, input logic [31:0] wdata);
    @(negedge clk);
    hValid = 1'b1; hWrite = wr; hRegSel = sel; hLane = lane; hSize = size;
    hWdata = wdata;
    @(negedge clk);
    hValid = 1'b0;
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset value
    request(2'd0, 1'b0, 2'd0, 2'd2, 32'h0);
    check(hAck && !hErr, "R1 ack", {hErr, hAck}, 32'h1);
    check(hRdata == 32'h0, "R1 reset value", hRdata, 32'h0);

    // R2: raw readback including low bits
    request(2'd0, 1'b1, 2'd0, 2'd2, 32'h00000A07);
    check(hAck && !dValid, "R2 write ack", {dValid, hAck}, 32'h1);
    request(2'd0, 1'b0, 2'd0, 2'd2, 32'h0);
    check(hRdata == 32'h00000A07, "R2 readback", hRdata, 32'h00000A07);

    // R3: partial-size and off-lane writes are rejected and leave the value
    request(2'd0, 1'b1, 2'd0, 2'd1, 32'hFFFFFFFF);
    check(hErr && !hAck, "R3 half write err", {hErr, hAck}, 32'h2);
    request(2'd0, 1'b1, 2'd2, 2'd2, 32'hFFFFFFFF);
    check(hErr && !hAck, "R3 lane2 write err", {hErr, hAck}, 32'h2);
    request(2'd0, 1'b1, 2'd0, 2'd0, 32'hFFFFFFFF);
    check(hErr, "R3 byte write err", {31'b0, hErr}, 32'h1);
    request(2'd0, 1'b0, 2'd0, 2'd2, 32'h0);
    check(hRdata == 32'h00000A07, "R3 value kept", hRdata, 32'h00000A07);

    // R9: idle cycle gives no response
    @(negedge clk);
    check(!hAck && !hErr && !dValid, "R9 idle quiet", {hAck, hErr, dValid}, 32'h0);

    // Table: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      request(VECS[i].sel, VECS[i].wr, VECS[i].lane, VECS[i].size, VECS[i].wdata);
      if (VECS[i].expErr) begin
        check(hErr && !hAck && !dValid, $sformatf("R7 R6 vec%0d reject", i),
              {hErr, hAck, dValid}, 32'h4);
      end else begin
        check(hAck && !hErr && dValid, $sformatf("R9 vec%0d accept", i),
              {hErr, hAck, dValid}, 32'h3);
        check(dAddr == VECS[i].expAddr,
              $sformatf("%s vec%0d addr", VECS[i].sel == 2'd2 ? "R5" : "R4", i),
              dAddr, VECS[i].expAddr);
        check(dIsIo == (VECS[i].sel == 2'd2), $sformatf("R4 R5 vec%0d space", i),
              {31'b0, dIsIo}, {31'b0, VECS[i].sel == 2'd2});
        check(dWdata == VECS[i].expData, $sformatf("R8 vec%0d data", i),
              dWdata, VECS[i].expData);
        check(dWrite == VECS[i].wr && dSize == VECS[i].size,
              $sformatf("R9 vec%0d dir size", i), {29'b0, dWrite, dSize},
              {29'b0, VECS[i].wr, VECS[i].size});
      end
    end

    // R4: bit 31 set still issues with cleared low bits
    request(2'd0, 1'b1, 2'd0, 2'd2, 32'h80FFFFFE);
    request(2'd1, 1'b0, 2'd1, 2'd0, 32'h0);
    check(dValid && dAddr == 32'h80FFFFFD, "R4 enable bit set", dAddr, 32'h80FFFFFD);
    request(2'd0, 1'b0, 2'd0, 2'd2, 32'h0);
    check(hRdata == 32'h80FFFFFE, "R2 second readback", hRdata, 32'h80FFFFFE);

    finishRun();
  end

endmodule